// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block is a seconds counter peripheral that sits on a simple 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. A one-cycle `tick` pulse, issued once per second by logic outside the block, moves a 32-bit up counter forward by one. It moves a companion down counter back by one, so the down counter always holds the complement of the up counter. Software sees only a raw seconds count. Two 32-bit compare slots watch the up counter. Each slot latches a status flag when the count equals its compare value. A latched flag raises the alarm interrupt when its enable bit is set. It can also drive a power-on-switch output, and that output can be forced high directly.

A small mode machine, derived from the control register, sets how the counter pair behaves:

- `ST_COUNT`: the pair advances on each tick.
- `ST_HOLD`: entered when the disable bit is set. The counter-disable bit freezes the pair, and the counter registers become writable.
- `ST_CLEAR`: entered when the software-reset bit is set. The software-reset bit pins the pair at zero and all-ones.

The transitions are as follows:

- `ST_CLEAR` is entered from any state whenever the reset bit is set.
- Leaving `ST_CLEAR` goes to `ST_HOLD` or `ST_COUNT`, according to the disable bit.
- `ST_COUNT` goes to `ST_HOLD` when the disable bit is set.
- `ST_HOLD` goes to `ST_COUNT` when the disable bit is cleared.

The state register updates on the same edge as the control register. The counters act on the new mode from the next edge on.

A 32-bit key register sits in a separate reset domain. It is cleared only by `por_n` and survives the bus reset `rst_n`. Software stores a magic word such as 0xB5C13F27 there and reads it back to decide whether first-time setup has already been done.

Top module: `sec_alarm_timer`

## Requirements
- R1: After `rst_n` the up count (offset 0x00) reads 0, the down count (0x04) reads 0xFFFFFFFF, both compare registers (0x08, 0x0C) read 0xFFFFFFFF, control (0x10) and status (0x14) read 0, and `alarm_irq` and `onsw_out` are low.
- R2: In `ST_COUNT` each cycle with `tick` high adds one to the up count and subtracts one from the down count. A cycle without a tick changes neither counter.
- R3: While control bit 6 (counter disable) is set, ticks are ignored and bus writes to offsets 0x00 and 0x04 load the counters. While bit 6 and bit 4 are both clear, such writes are ignored.
- R4: While control bit 4 (software reset) is set, the up count is held at 0 and the down count at 0xFFFFFFFF, whatever bit 6 and `tick` are. The control and compare registers keep their values.
- R5: Status bit n (n = 0 for compare slot 0 at 0x08, n = 1 for slot 1 at 0x0C) sets on the edge where the up count becomes equal to the compare value. Writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R6: A clear written to a status bit loses to a match present in the same cycle, so a flag cannot be cleared while the up count still equals its compare value.
- R7: `alarm_irq` is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1).
- R8: `onsw_out` is high when control bit 7 is set, or status bit 0 with control bit 2, or status bit 1 with control bit 3. Status bit 2 latches whenever a match drives `onsw_out`, and it is cleared by writing 1.
- R9: The key register at offset 0x18 reads back what was written. It keeps its value through `rst_n` and is cleared to 0 only by `por_n`.
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 return 0, and writes there change nothing. Control bit 5 and bits 31..8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| por_n | input | 1 | Active-low power-on reset, clears the key register only |
| rst_n | input | 1 | Active-low bus reset for everything except the key |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, applies on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt request |
| onsw_out | output | 1 | Power-on-switch drive |

## Verification
The step assertions in the counter pair take for granted that `tick` lasts one cycle. They also assume counter loads arrive only while the mode machine is in `ST_HOLD`; a load attempted in `ST_COUNT` is meant to be dropped, and the bench checks this through the read port. The equal-implies-latched property in each compare slot assumes compare values and counter loads come only through the bus. The stimulus drives every access in full on a falling edge. It spaces random ticks with idle gaps and moves compare values to 0xFFFFFFFF before clearing flags, which is how software retires an alarm.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned CTRL_W = 8;

    // byte offsets of the register bank
    localparam logic [7:0] OFS_UP    = 8'h00;
    localparam logic [7:0] OFS_DOWN  = 8'h04;
    localparam logic [7:0] OFS_CMP0  = 8'h08;
    localparam logic [7:0] OFS_CMP1  = 8'h0C;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_KEY   = 8'h18;

    // control bit positions
    localparam int unsigned CB_IRQ0   = 0;
    localparam int unsigned CB_IRQ1   = 1;
    localparam int unsigned CB_SW0    = 2;
    localparam int unsigned CB_SW1    = 3;
    localparam int unsigned CB_SRST   = 4;
    localparam int unsigned CB_HALT   = 6;
    localparam int unsigned CB_FORCE  = 7;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

    // status bit positions
    localparam int unsigned SB_SW = 2;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_HOLD  = 2'd1,
        ST_CLEAR = 2'd2
    } mode_e;

endpackage

// File: rtl/sat_mode_fsm.sv
module sat_mode_fsm
    import sat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    input  logic halt_req,
    output logic run_en,
    output logic hold_en,
    output logic clear_en
);

    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (srst_req)      state_d = ST_CLEAR;
                else if (halt_req) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (srst_req)       state_d = ST_CLEAR;
                else if (!halt_req) state_d = ST_COUNT;
            end
            ST_CLEAR: begin
                if (!srst_req) state_d = halt_req ? ST_HOLD : ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        run_en   = 1'b0;
        hold_en  = 1'b0;
        clear_en = 1'b0;
        unique case (state_q)
            ST_COUNT: run_en   = 1'b1;
            ST_HOLD:  hold_en  = 1'b1;
            ST_CLEAR: clear_en = 1'b1;
            default:  run_en   = 1'b1;
        endcase
    end

    // R4: a software-reset request always lands in the clear mode
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> clear_en);

endmodule

// File: rtl/sat_counter_pair.sv
module sat_counter_pair #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         hold_en,
    input  logic         clear_en,
    input  logic         tick,
    input  logic         wr_up,
    input  logic         wr_dn,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] up_q,
    output logic [W-1:0] dn_q,
    output logic [W-1:0] up_d
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] dn_d;

    always_comb begin
        up_d = up_q;
        dn_d = dn_q;
        if (clear_en) begin
            up_d = '0;
            dn_d = ALL_ONES;
        end else if (hold_en) begin
            if (wr_up) up_d = wdata;
            if (wr_dn) dn_d = wdata;
        end else if (run_en && tick) begin
            up_d = up_q + ONE;
            dn_d = dn_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= ALL_ONES;
        end else begin
            up_q <= up_d;
            dn_q <= dn_d;
        end
    end

    // R2: a tick in count mode steps both counters by one in opposite senses
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick) |=> (up_q == $past(up_q) + ONE) && (dn_q == $past(dn_q) - ONE));

    // R3: hold mode without a load keeps both counters
    p_hold_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && !wr_up && !wr_dn) |=> ($stable(up_q) && $stable(dn_q)));

    // R4: clear mode pins the pair
    p_clear_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en |=> (up_q == '0) && (dn_q == ALL_ONES));

endmodule

// File: rtl/sat_match_slot.sv
module sat_match_slot #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    input  logic         clr_req,
    input  logic [W-1:0] up_d,
    input  logic [W-1:0] up_q,
    output logic [W-1:0] cmp_q,
    output logic         flag_d,
    output logic         flag_q
);

    logic [W-1:0] cmp_d;
    logic         hit;

    always_comb begin
        cmp_d  = wr_cmp ? wdata : cmp_q;
        hit    = (up_d == cmp_d);
        // a new match outranks a clear in the same cycle
        flag_d = hit | (flag_q & ~clr_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= {W{1'b1}};
            flag_q <= 1'b0;
        end else begin
            cmp_q  <= cmp_d;
            flag_q <= flag_d;
        end
    end

    // R5/R6: whenever the count sits on the compare value the flag is up
    p_equal_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == cmp_q) |-> flag_q);

    // R6: a clear cannot drop the flag while the match persists
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr_req && (up_d == cmp_d)) |=> flag_q);

endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
    import sat_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq,
    output logic              onsw_out
);

    localparam int unsigned NUM_CMP = 2;
    localparam int unsigned STAT_W  = NUM_CMP + 1;

    localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(OFS_UP);
    localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(OFS_DOWN);
    localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(OFS_CMP0);
    localparam logic [ADDR_W-1:0] A_CMP1 = ADDR_W'(OFS_CMP1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic              sw_flag_q, sw_flag_d;
    logic [DATA_W-1:0] key_q;

    logic run_en, hold_en, clear_en;
    logic [DATA_W-1:0] up_q, dn_q, up_d;

    logic [DATA_W-1:0] cmp_q  [NUM_CMP];
    logic [NUM_CMP-1:0] flag_d, flag_q, cmp_wr;
    logic [NUM_CMP-1:0] irq_en_d, irq_en_q, sw_en_d, sw_en_q;

    logic wr_ctrl, wr_stat;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign ctrl_d  = wr_ctrl ? (bus_wdata[CTRL_W-1:0] & CTRL_MASK) : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // mode machine follows the control register on the same edge
    sat_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_req (ctrl_d[CB_SRST]),
        .halt_req (ctrl_d[CB_HALT]),
        .run_en   (run_en),
        .hold_en  (hold_en),
        .clear_en (clear_en)
    );

    sat_counter_pair #(.W(DATA_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .hold_en  (hold_en),
        .clear_en (clear_en),
        .tick     (tick),
        .wr_up    (bus_we && (bus_addr == A_UP)),
        .wr_dn    (bus_we && (bus_addr == A_DOWN)),
        .wdata    (bus_wdata),
        .up_q     (up_q),
        .dn_q     (dn_q),
        .up_d     (up_d)
    );

    assign cmp_wr[0]   = bus_we && (bus_addr == A_CMP0);
    assign cmp_wr[1]   = bus_we && (bus_addr == A_CMP1);
    assign irq_en_d[0] = ctrl_d[CB_IRQ0];
    assign irq_en_d[1] = ctrl_d[CB_IRQ1];
    assign irq_en_q[0] = ctrl_q[CB_IRQ0];
    assign irq_en_q[1] = ctrl_q[CB_IRQ1];
    assign sw_en_d[0]  = ctrl_d[CB_SW0];
    assign sw_en_d[1]  = ctrl_d[CB_SW1];
    assign sw_en_q[0]  = ctrl_q[CB_SW0];
    assign sw_en_q[1]  = ctrl_q[CB_SW1];

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_slot
        sat_match_slot #(.W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cmp  (cmp_wr[gi]),
            .wdata   (bus_wdata),
            .clr_req (wr_stat && bus_wdata[gi]),
            .up_d    (up_d),
            .up_q    (up_q),
            .cmp_q   (cmp_q[gi]),
            .flag_d  (flag_d[gi]),
            .flag_q  (flag_q[gi])
        );
    end

    // switch-status flag: set whenever a match is driving the switch
    assign sw_flag_d = (|(flag_d & sw_en_d)) | (sw_flag_q & ~(wr_stat && bus_wdata[SB_SW]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_flag_q <= 1'b0;
        else        sw_flag_q <= sw_flag_d;
    end

    // key lives in the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                          key_q <= '0;
        else if (bus_we && bus_addr == A_KEY) key_q <= bus_wdata;
    end

    assign alarm_irq = |(flag_q & irq_en_q);
    assign onsw_out  = ctrl_q[CB_FORCE] | (|(flag_q & sw_en_q));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_UP:    bus_rdata = up_q;
            A_DOWN:  bus_rdata = dn_q;
            A_CMP0:  bus_rdata = cmp_q[0];
            A_CMP1:  bus_rdata = cmp_q[1];
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_STAT:  bus_rdata = DATA_W'({sw_flag_q, flag_q});
            A_KEY:   bus_rdata = key_q;
            default: bus_rdata = '0;
        endcase
    end

    // R7: the interrupt never rises without an enable bit
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (ctrl_q[CB_IRQ0] | ctrl_q[CB_IRQ1]));

    // R8: the force bit always wins on the switch output
    p_force_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_FORCE] |-> onsw_out);

    // R8: a match driving the switch leaves the switch-status flag set
    p_sw_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (onsw_out && !ctrl_q[CB_FORCE]) |-> sw_flag_q);

    // R10: reserved control bits stay zero on readback
    p_ctrl_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0 && bus_rdata[5] == 1'b0));

endmodule

// File: tb/tb_sec_alarm_timer.sv
module tb_sec_alarm_timer;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq, onsw_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_up;
    logic [31:0] rv;

    localparam logic [31:0] MAGIC = 32'hB5C13F27;

    sec_alarm_timer dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq), .onsw_out(onsw_out)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_down(input logic [31:0] u);
        return 32'hFFFFFFFF - u;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic check_pair(input string tag);
        rd(8'h00, rv); check({tag, " up"}, rv, m_up);
        rd(8'h04, rv); check({tag, " down"}, rv, exp_down(m_up));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        idle(2);

        // R1 reset state
        m_up = 0;
        check_pair("R1");
        rd(8'h08, rv); check("R1 cmp0", rv, 32'hFFFFFFFF);
        rd(8'h0C, rv); check("R1 cmp1", rv, 32'hFFFFFFFF);
        rd(8'h10, rv); check("R1 ctrl", rv, 0);
        rd(8'h14, rv); check("R1 stat", rv, 0);
        check("R1 irq", {31'd0, alarm_irq}, 0);
        check("R1 onsw", {31'd0, onsw_out}, 0);

        // R2 ticks with idle gaps
        for (int i = 0; i < 5; i++) begin
            pulse_tick();
            m_up++;
            idle($urandom % 3);
        end
        check_pair("R2");

        // R3 hold mode and loads
        wr(8'h10, 32'h40);
        pulse_tick(); pulse_tick(); pulse_tick();
        check_pair("R3 hold");
        wr(8'h00, 32'd1000);
        wr(8'h04, exp_down(32'd1000));
        m_up = 1000;
        check_pair("R3 load");
        wr(8'h10, 32'h0);
        wr(8'h00, 32'd7);
        check_pair("R3 run-write ignored");
        pulse_tick(); m_up++;
        check_pair("R3 resume");

        // R4 software reset
        wr(8'h08, 32'h55);
        wr(8'h10, 32'h50);
        idle(1);
        m_up = 0;
        check_pair("R4 clear");
        pulse_tick();
        check_pair("R4 tick held");
        rd(8'h10, rv); check("R4 ctrl kept", rv, 32'h50);
        rd(8'h08, rv); check("R4 cmp kept", rv, 32'h55);
        wr(8'h10, 32'h0);
        pulse_tick(); pulse_tick(); m_up += 2;
        check_pair("R4 release");
        wr(8'h08, 32'hFFFFFFFF);

        // R5 / R6 match latching
        wr(8'h08, m_up + 3);
        pulse_tick(); pulse_tick(); m_up += 2;
        rd(8'h14, rv); check("R5 before match", rv, 0);
        pulse_tick(); m_up++;
        rd(8'h14, rv); check("R5 match set", rv, 1);
        check("R7 irq disabled", {31'd0, alarm_irq}, 0);
        wr(8'h14, 32'h0);
        rd(8'h14, rv); check("R5 write0 keeps", rv, 1);
        wr(8'h14, 32'h1);
        rd(8'h14, rv); check("R6 set beats clear", rv, 1);
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h14, rv); check("R5 still latched", rv, 1);
        wr(8'h14, 32'h1);
        rd(8'h14, rv); check("R5 cleared", rv, 0);

        // R7 interrupt gating
        wr(8'h10, 32'h1);
        wr(8'h08, m_up + 2);
        pulse_tick(); pulse_tick(); m_up += 2;
        check("R7 irq high", {31'd0, alarm_irq}, 1);
        wr(8'h10, 32'h0);
        check("R7 irq masked", {31'd0, alarm_irq}, 0);
        wr(8'h10, 32'h1);
        check("R7 irq reenabled", {31'd0, alarm_irq}, 1);
        wr(8'h08, 32'hFFFFFFFF);
        wr(8'h14, 32'h1);
        check("R7 irq after clear", {31'd0, alarm_irq}, 0);
        wr(8'h10, 32'h0);

        // R8 power-on switch
        wr(8'h10, 32'h80);
        check("R8 force", {31'd0, onsw_out}, 1);
        check("R8 force no irq", {31'd0, alarm_irq}, 0);
        wr(8'h10, 32'h08);
        check("R8 idle low", {31'd0, onsw_out}, 0);
        wr(8'h0C, m_up + 1);
        pulse_tick(); m_up++;
        check("R8 match drives", {31'd0, onsw_out}, 1);
        rd(8'h14, rv); check("R8 stat", rv, 32'h6);
        check("R8 irq off", {31'd0, alarm_irq}, 0);
        wr(8'h0C, 32'hFFFFFFFF);
        wr(8'h14, 32'h7);
        rd(8'h14, rv); check("R8 stat cleared", rv, 0);
        check("R8 low again", {31'd0, onsw_out}, 0);
        wr(8'h10, 32'h0);

        // R9 key domain
        wr(8'h18, MAGIC);
        rd(8'h18, rv); check("R9 key rd", rv, MAGIC);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
        m_up = 0;
        rd(8'h18, rv); check("R9 key kept", rv, MAGIC);
        check_pair("R9 bus reset");
        @(negedge clk); por_n = 1'b0; idle(2); por_n = 1'b1;
        rd(8'h18, rv); check("R9 key por", rv, 0);

        // R10 undefined offsets and reserved bits
        rd(8'h1C, rv); check("R10 rd 1C", rv, 0);
        rd(8'h05, rv); check("R10 rd 05", rv, 0);
        wr(8'h1C, 32'h12345678);
        wr(8'h01, 32'hFFFFFFFF);
        rd(8'h08, rv); check("R10 cmp0 untouched", rv, 32'hFFFFFFFF);
        rd(8'h10, rv); check("R10 ctrl untouched", rv, 0);
        check_pair("R10 counters untouched");
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, rv); check("R10 ctrl mask", rv, 32'hDF);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h7);
        idle(1);

        // random alarm distances: R2 and R5
        for (int i = 0; i < 30; i++) begin
            int unsigned k;
            k = 1 + ($urandom % 6);
            wr(8'h08, m_up + k);
            for (int j = 0; j < k - 1; j++) begin
                pulse_tick(); m_up++;
                idle($urandom % 3);
            end
            rd(8'h14, rv); check("R5 rand early", rv & 32'h1, 0);
            pulse_tick(); m_up++;
            rd(8'h14, rv); check("R5 rand hit", rv & 32'h1, 1);
            check_pair("R2 rand");
            wr(8'h08, 32'hFFFFFFFF);
            wr(8'h14, 32'h1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule